// File: doc/BRIEF.md
# Transmit Interrupt Delay Timer

This block raises the transmit-completion interrupt for a network transmit engine. Whenever the engine writes back the status of a transmit descriptor, it presents a one-cycle write-back strobe with two command bits. The report bit asks for completion to be signalled. The delay bit asks for that signal to be postponed. The block also reads a programmable delay value and a mask-enable bit for the write-back interrupt source.

A delayed report loads a countdown timer with the programmed delay. Each later delayed report reloads the timer, so a burst of completions produces one interrupt after the traffic goes quiet. The timer steps down by one on each pulse of a prescaler tick input. When the count runs out, the block issues a single-cycle interrupt request, provided the mask enable is set at that moment.

An undelayed report fires the interrupt at once and cancels any countdown still running. A delay value of zero counts as undelayed. Write-backs without the report bit are ignored. The interrupt request comes from a register, so it appears in the cycle after the clock edge that decided it.

Top module: `txirq_delay_timer`

## Requirements
- R1: During reset and after reset, `irq_pulse` is 0 and the timer is idle (count 0). While idle, tick pulses alone never produce an interrupt.
- R2: A write-back with `wb_rpt`=1, `wb_dly`=1 and a nonzero `dly_value` V loads the count with V. With no further write-backs, `irq_pulse` is 1 in the cycle after the clock edge that carries the V-th tick following the load edge.
- R3: A delayed write-back while a countdown is running reloads the count from `dly_value`. The interrupt is then timed from the newest load only.
- R4: If `irq_mask_en` is 0 at the edge where the count expires, no interrupt is issued and the timer returns to idle. Setting the mask enable afterwards does not bring back the lost interrupt.
- R5: A write-back with `wb_rpt`=1 and `wb_dly`=0 sets `irq_pulse` in the cycle after that write-back edge, provided `irq_mask_en` is 1 at that edge. If `irq_mask_en` is 0, no interrupt is issued.
- R6: An immediate interrupt (R5 or R7) clears any pending countdown, so no second interrupt follows from it.
- R7: A write-back with `wb_rpt`=1, `wb_dly`=1 and `dly_value`=0 behaves exactly like the immediate case of R5.
- R8: A write-back with `wb_rpt`=0 changes neither the count nor `irq_pulse`, whatever the values of `wb_dly` and `dly_value`.
- R9: Each interrupt event drives `irq_pulse` high for exactly one cycle.
- R10: Without a tick, the count holds its value and no expiry occurs.
- R11: If a delayed write-back arrives at the same edge as the tick that would expire the count, the reload wins. No interrupt is issued at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_valid | input | 1 | One-cycle strobe: a descriptor status write-back happened |
| wb_rpt | input | 1 | Report bit of the written-back descriptor |
| wb_dly | input | 1 | Delay-enable bit of the written-back descriptor |
| dly_value | input | DLY_W | Programmed delay, counted in ticks |
| irq_mask_en | input | 1 | Mask enable for the write-back interrupt |
| tick | input | 1 | Prescaler enable; one count step per high cycle |
| irq_pulse | output | 1 | Registered one-cycle interrupt request |

## Verification
The assertions assume that `dly_value` and `irq_mask_en` are stable, synchronous inputs sampled only at clock edges. They also assume that `wb_valid` is a single-cycle strobe whose command bits are meaningful only while it is high. The stimulus changes every input just after a falling edge and holds `wb_valid` for one edge per write-back, so every event is seen exactly once. The delay sweeps stay within the 3-bit configuration of the bench. Ticks come either on every cycle or once every three cycles, so the expected expiry edge is simply the delay multiplied by the tick spacing.

// File: rtl/txirq_pkg.sv
package txirq_pkg;

  // Classification of a write-back strobe.
  typedef enum logic [1:0] {
    WB_NONE = 2'd0,  // nothing to do for the timer
    WB_LOAD = 2'd1,  // start or restart the countdown
    WB_FIRE = 2'd2   // interrupt now and cancel the countdown
  } wb_kind_e;

  function automatic wb_kind_e classify_wb(input logic valid,
                                           input logic rpt,
                                           input logic dly,
                                           input logic dly_is_zero);
    wb_kind_e k;
    k = WB_NONE;
    if (valid && rpt) begin
      if (dly && !dly_is_zero) k = WB_LOAD;
      else                     k = WB_FIRE;
    end
    return k;
  endfunction

endpackage

// File: rtl/txirq_event_decode.sv
module txirq_event_decode
  import txirq_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             wb_valid,
  input  logic             wb_rpt,
  input  logic             wb_dly,
  input  logic [DLY_W-1:0] dly_value,
  output wb_kind_e         kind
);

  logic dly_zero;

  // A zero delay is handled as an undelayed report.
  assign dly_zero = (dly_value == '0);

  always_comb begin
    kind = classify_wb(wb_valid, wb_rpt, wb_dly, dly_zero);
  end

endmodule

// File: rtl/txirq_countdown.sv
module txirq_countdown
  import txirq_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  wb_kind_e         kind,
  input  logic [DLY_W-1:0] dly_value,
  input  logic             tick,
  output logic [DLY_W-1:0] cnt_q,
  output logic             expire
);

  localparam logic [DLY_W-1:0] LAST = DLY_W'(1);

  logic counting;

  assign counting = (cnt_q != '0);

  // Expiry only when no write-back event overrides this edge.
  assign expire = (kind == WB_NONE) && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case (kind)
        WB_LOAD: cnt_q <= dly_value;
        WB_FIRE: cnt_q <= '0;
        default: begin
          if (tick && counting) cnt_q <= cnt_q - LAST;
        end
      endcase
    end
  end

endmodule

// File: rtl/txirq_fire_stage.sv
module txirq_fire_stage (
  input  logic clk,
  input  logic rst,
  input  logic fire_now,
  input  logic mask_en,
  output logic irq_q
);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= fire_now && mask_en;
  end

endmodule

// File: rtl/txirq_delay_timer.sv
module txirq_delay_timer
  import txirq_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wb_valid,
  input  logic             wb_rpt,
  input  logic             wb_dly,
  input  logic [DLY_W-1:0] dly_value,
  input  logic             irq_mask_en,
  input  logic             tick,
  output logic             irq_pulse
);

  wb_kind_e         kind;
  logic [DLY_W-1:0] cnt_q;
  logic             expire;
  logic             fire_now;

  txirq_event_decode #(.DLY_W(DLY_W)) u_decode (
    .wb_valid (wb_valid),
    .wb_rpt   (wb_rpt),
    .wb_dly   (wb_dly),
    .dly_value(dly_value),
    .kind     (kind)
  );

  txirq_countdown #(.DLY_W(DLY_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .dly_value(dly_value),
    .tick     (tick),
    .cnt_q    (cnt_q),
    .expire   (expire)
  );

  assign fire_now = (kind == WB_FIRE) || expire;

  txirq_fire_stage u_fire (
    .clk     (clk),
    .rst     (rst),
    .fire_now(fire_now),
    .mask_en (irq_mask_en),
    .irq_q   (irq_pulse)
  );

endmodule

// File: rtl/txirq_delay_timer_chk.sv
module txirq_delay_timer_chk #(
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wb_valid,
  input logic             wb_rpt,
  input logic             wb_dly,
  input logic [DLY_W-1:0] dly_value,
  input logic             irq_mask_en,
  input logic             tick,
  input logic             irq_pulse,
  input logic [DLY_W-1:0] cnt_q
);

  logic ev_load, ev_fire, ev_none;
  assign ev_load = wb_valid && wb_rpt && wb_dly && (dly_value != '0);
  assign ev_fire = wb_valid && wb_rpt && (!wb_dly || (dly_value == '0));
  assign ev_none = !(wb_valid && wb_rpt);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!irq_pulse && cnt_q == '0));

  assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
    ev_load |=> (cnt_q == $past(dly_value)));

  assert_expiry_fires_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_none && tick && cnt_q == DLY_W'(1) && irq_mask_en) |=> irq_pulse);

  assert_irq_needs_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (!irq_mask_en) |=> !irq_pulse);

  assert_immediate_fires_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_fire && irq_mask_en) |=> irq_pulse);

  assert_immediate_clears_R6: assert property (@(posedge clk) disable iff (rst)
    ev_fire |=> (cnt_q == '0));

  assert_ignore_no_report_R8: assert property (@(posedge clk) disable iff (rst)
    (ev_none && !tick) |=> (!irq_pulse && $stable(cnt_q)));

  assert_step_down_R10: assert property (@(posedge clk) disable iff (rst)
    (ev_none && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - DLY_W'(1)));

  assert_reload_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (ev_load && tick && cnt_q == DLY_W'(1)) |=> !irq_pulse);

endmodule

bind txirq_delay_timer txirq_delay_timer_chk #(.DLY_W(DLY_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wb_valid   (wb_valid),
  .wb_rpt     (wb_rpt),
  .wb_dly     (wb_dly),
  .dly_value  (dly_value),
  .irq_mask_en(irq_mask_en),
  .tick       (tick),
  .irq_pulse  (irq_pulse),
  .cnt_q      (cnt_q)
);

// File: tb/tb_txirq_delay_timer.sv
`timescale 1ns/1ps
module tb_txirq_delay_timer;

  localparam int DLY_W = 3;
  localparam int VMAX  = (1 << DLY_W) - 1;
  localparam real HALF = 10.0;

  logic             clk = 1'b0;
  logic             rst;
  logic             wb_valid, wb_rpt, wb_dly;
  logic [DLY_W-1:0] dly_value;
  logic             irq_mask_en;
  logic             tick;
  logic             irq_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(HALF) clk = ~clk;

  txirq_delay_timer #(.DLY_W(DLY_W)) dut (
    .clk(clk), .rst(rst), .wb_valid(wb_valid), .wb_rpt(wb_rpt),
    .wb_dly(wb_dly), .dly_value(dly_value), .irq_mask_en(irq_mask_en),
    .tick(tick), .irq_pulse(irq_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wb(input bit v, input bit r, input bit d, input int val);
    wb_valid  = v;
    wb_rpt    = r;
    wb_dly    = d;
    dly_value = DLY_W'(val);
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // Delayed load of V, ticks every P cycles, returns first irq edge and irq count.
  task automatic run_delay(input int v, input int p, input bit mask,
                           output int first, output int cnt);
    first = -1;
    cnt   = 0;
    irq_mask_en = mask;
    wb(1, 1, 1, v);
    tick = 1'b0;
    cyc();
    wb(0, 0, 0, 0);
    chk(irq_pulse == 1'b0, "R2 no irq at load edge", irq_pulse, 0);
    for (int i = 1; i <= v * p + 4; i++) begin
      tick = ((i % p) == 0);
      cyc();
      if (irq_pulse) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    tick = 1'b0;
  endtask

  initial begin
    #(HALF * 2.0 * 200000.0);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int first, cnt;
    rst = 1'b1;
    wb(0, 0, 0, 0);
    irq_mask_en = 1'b1;
    tick = 1'b0;
    repeat (3) cyc();
    chk(irq_pulse == 1'b0, "R1 reset irq low", irq_pulse, 0);
    rst = 1'b0;
    // R1: ticks alone on an idle timer
    cnt = 0;
    tick = 1'b1;
    for (int i = 0; i < 12; i++) begin
      cyc();
      if (irq_pulse) cnt++;
    end
    tick = 1'b0;
    chk(cnt == 0, "R1 idle ticks no irq", cnt, 0);

    // R2/R9/R10: sweep all nonzero delays, two tick spacings
    for (int p = 1; p <= 3; p += 2) begin
      for (int v = 1; v <= VMAX; v++) begin
        run_delay(v, p, 1'b1, first, cnt);
        chk(first == v * p, "R2 expiry edge", first, v * p);
        chk(cnt == 1, "R9 single pulse", cnt, 1);
      end
    end

    // R10: no ticks for a while, then ticking
    irq_mask_en = 1'b1;
    wb(1, 1, 1, 3); tick = 1'b0; cyc(); wb(0, 0, 0, 0);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin cyc(); if (irq_pulse) cnt++; end
    chk(cnt == 0, "R10 hold without tick", cnt, 0);
    tick = 1'b1; first = -1;
    for (int i = 1; i <= 6; i++) begin cyc(); if (irq_pulse && first < 0) first = i; end
    tick = 1'b0;
    chk(first == 3, "R10 resumes count", first, 3);

    // R3: reload mid countdown (5, then 4 after 3 ticks)
    wb(1, 1, 1, 5); tick = 1'b0; cyc(); wb(0, 0, 0, 0);
    tick = 1'b1; first = -1; cnt = 0;
    for (int i = 1; i <= 12; i++) begin
      if (i == 3) wb(1, 1, 1, 4); else wb(0, 0, 0, 0);
      cyc();
      if (irq_pulse) begin cnt++; if (first < 0) first = i; end
    end
    wb(0, 0, 0, 0); tick = 1'b0;
    chk(first == 7, "R3 reload timing", first, 7);
    chk(cnt == 1, "R3 one irq after reload", cnt, 1);

    // R4: mask off at expiry, then on: dropped
    run_delay(3, 1, 1'b0, first, cnt);
    chk(cnt == 0, "R4 masked expiry", cnt, 0);
    irq_mask_en = 1'b1; tick = 1'b1; cnt = 0;
    for (int i = 0; i < 10; i++) begin cyc(); if (irq_pulse) cnt++; end
    tick = 1'b0;
    chk(cnt == 0, "R4 no late irq", cnt, 0);

    // R5/R9: immediate
    irq_mask_en = 1'b1;
    wb(1, 1, 0, 6); cyc(); wb(0, 0, 0, 0);
    chk(irq_pulse == 1'b1, "R5 immediate irq", irq_pulse, 1);
    cyc();
    chk(irq_pulse == 1'b0, "R9 pulse ends", irq_pulse, 0);
    irq_mask_en = 1'b0;
    wb(1, 1, 0, 6); cyc(); wb(0, 0, 0, 0);
    chk(irq_pulse == 1'b0, "R5 masked immediate", irq_pulse, 0);
    irq_mask_en = 1'b1;

    // R6: immediate cancels countdown
    wb(1, 1, 1, 5); cyc();
    wb(0, 0, 0, 0); tick = 1'b1; cyc(); cyc();
    wb(1, 1, 0, 0); cyc(); wb(0, 0, 0, 0);
    chk(irq_pulse == 1'b1, "R6 immediate irq", irq_pulse, 1);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin cyc(); if (irq_pulse) cnt++; end
    tick = 1'b0;
    chk(cnt == 0, "R6 countdown cancelled", cnt, 0);

    // R7: zero delay with delay bit is immediate and clears
    wb(1, 1, 1, 4); cyc();
    wb(1, 1, 1, 0); cyc(); wb(0, 0, 0, 0);
    chk(irq_pulse == 1'b1, "R7 zero delay immediate", irq_pulse, 1);
    tick = 1'b1; cnt = 0;
    for (int i = 0; i < 8; i++) begin cyc(); if (irq_pulse) cnt++; end
    tick = 1'b0;
    chk(cnt == 0, "R7 no later irq", cnt, 0);

    // R8: report clear ignored, idle and during countdown
    for (int d = 0; d < 2; d++) begin
      wb(1, 0, d[0], 5); cyc(); wb(0, 0, 0, 0);
      chk(irq_pulse == 1'b0, "R8 idle ignore", irq_pulse, 0);
    end
    wb(1, 1, 1, 4); tick = 1'b0; cyc(); wb(0, 0, 0, 0);
    tick = 1'b1; first = -1; cnt = 0;
    for (int i = 1; i <= 8; i++) begin
      if (i == 2) wb(1, 0, 1, 7); else if (i == 3) wb(1, 0, 0, 1); else wb(0, 0, 0, 0);
      cyc();
      if (irq_pulse) begin cnt++; if (first < 0) first = i; end
    end
    wb(0, 0, 0, 0); tick = 1'b0;
    chk(first == 4, "R8 countdown unaffected", first, 4);
    chk(cnt == 1, "R8 single irq", cnt, 1);

    // R11: reload on the expiring tick
    wb(1, 1, 1, 2); tick = 1'b0; cyc(); wb(0, 0, 0, 0);
    tick = 1'b1; first = -1;
    for (int i = 1; i <= 8; i++) begin
      if (i == 2) wb(1, 1, 1, 3); else wb(0, 0, 0, 0);
      cyc();
      if (i == 2) chk(irq_pulse == 1'b0, "R11 no irq at reload edge", irq_pulse, 0);
      if (irq_pulse && first < 0) first = i;
    end
    wb(0, 0, 0, 0); tick = 1'b0;
    chk(first == 5, "R11 restart timing", first, 5);

    // R1: reset mid countdown returns to idle
    wb(1, 1, 1, 2); cyc(); wb(0, 0, 0, 0);
    rst = 1'b1; cyc(); rst = 1'b0;
    tick = 1'b1; cnt = 0;
    for (int i = 0; i < 6; i++) begin cyc(); if (irq_pulse) cnt++; end
    tick = 1'b0;
    chk(cnt == 0, "R1 reset clears countdown", cnt, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule